// File: doc/BRIEF.md
# Coherence Response Classifier with Ack Counting

This block sits between the channel that delivers coherence responses to a private cache and the controller that walks each line through its transient states. Every miss in flight owns a slot holding a signed count of acknowledgements still owed. For each accepted response the block reads the message kind, whether the sender was a peer private cache, the signed count the message carries and the line's current state, which the controller supplies. From these it produces one event code for the controller.

The slot's count is rewritten whenever a plain data or ack response is accepted. Acks carry +1 each. Data from the shared level carries the negated number of sharers. Either kind of response may arrive first, so the count can go negative for a while and returns to zero when the last piece lands. The controller claims a slot when a miss starts and frees it when the miss retires. A response aimed at a free slot, or with an unknown kind, produces a fault event.

Responses enter through a valid/ready handshake, and events leave through a registered valid/ready stage with one cycle of latency.

Top module: `coh_rsp_classifier`

## Requirements
- R1: After reset no event is valid, `rsp_ready` is 1, and every slot is free, so any response then yields the fault code 7.
- R2: A response of kind 1 (exclusive data) to a claimed slot yields code 0 whatever the counts are, reports the stored count on `ev_remain`, and leaves the count unchanged.
- R3: A response of kind 0 (data) with `rsp_from_l1`=1, while `line_state` is 1 (load pending) or 2 (load pending, invalidated), yields code 1, reports the stored count, and leaves the count unchanged.
- R4: Any other kind-0 response yields code 2 when the stored count minus the carried count is zero, and code 3 otherwise.
- R5: A response of kind 2 (ack) yields code 4 when the stored count minus the carried count is zero, and code 5 otherwise.
- R6: For responses classified under R4 or R5, the slot's count becomes the stored count minus the sign-extended carried count, wrapping in CNT_W-bit two's complement, and `ev_remain` reports that new value.
- R7: Claiming a slot sets its count to zero and marks it claimed, and freeing a slot clears its count and marks it free. A claim or free at the same edge as a count update to that slot overrides the update, and a claim overrides a free.
- R8: A response of kind 3 (writeback ack) to a claimed slot yields code 6 and reports the stored count.
- R9: A response of kind 4 to 7, or any response to a free slot, yields code 7 with `ev_remain` 0 and changes no count.
- R10: `rsp_ready` equals NOT `ev_valid` OR `ev_ready`. An accepted response appears on the event port at the next edge with its slot index, and an event held while `ev_ready` is 0 keeps all of its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Claim a slot for a new miss |
| alloc_idx | input | IDX_W | Slot to claim |
| release_valid | input | 1 | Free a slot when its miss retires |
| release_idx | input | IDX_W | Slot to free |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response accepted at this edge when high |
| rsp_kind | input | 3 | 0 data, 1 exclusive data, 2 ack, 3 writeback ack, others invalid |
| rsp_from_l1 | input | 1 | Sender is a peer private cache |
| rsp_acks | input | ACK_W | Signed count carried by the response |
| rsp_idx | input | IDX_W | Slot the response belongs to |
| line_state | input | STATE_W | Controller state of the line (1, 2 = load pending) |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Controller takes the event |
| ev_code | output | 3 | Event code 0..7 |
| ev_idx | output | IDX_W | Slot the event belongs to |
| ev_remain | output | CNT_W | Signed count reported with the event |

## Verification
The hardest state to reach from the ports is a slot whose count sits below zero: several acks have arrived before the data that carries the negated sharer total. It must stay correct even when a free or claim lands on the same edge as an update to that slot. Directed sequences send acks first and data last, and in the other order, to separate slots. A further sequence frees a slot in the very cycle an ack for it is accepted and then reclaims it. A long random phase mixes claims, frees, signed carried counts, stalls on the event port and invalid kinds, and a behavioural model checks every cycle.

// File: rtl/coh_rsp_pkg.sv
package coh_rsp_pkg;

  typedef enum logic [2:0] {
    MSG_DATA      = 3'd0,
    MSG_DATA_EXCL = 3'd1,
    MSG_ACK       = 3'd2,
    MSG_WB_ACK    = 3'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    EV_DATA_EXCL = 3'd0,
    EV_DATA_PEER = 3'd1,
    EV_DATA_DONE = 3'd2,
    EV_DATA_PART = 3'd3,
    EV_ACK_DONE  = 3'd4,
    EV_ACK_PART  = 3'd5,
    EV_WB_DONE   = 3'd6,
    EV_FAULT     = 3'd7
  } evt_code_e;

  localparam int LS_LOAD_WAIT     = 1;
  localparam int LS_LOAD_WAIT_INV = 2;

endpackage

// File: rtl/rsp_ack_ledger.sv
module rsp_ack_ledger #(
  parameter int N_ENTRY = 4,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    claim_en,
  input  logic [IDX_W-1:0]        claim_idx,
  input  logic                    free_en,
  input  logic [IDX_W-1:0]        free_idx,
  input  logic                    upd_en,
  input  logic [IDX_W-1:0]        upd_idx,
  input  logic signed [CNT_W-1:0] upd_val,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic                    rd_claimed,
  output logic signed [CNT_W-1:0] rd_cnt
);

  logic [N_ENTRY-1:0]        claimed_q;
  logic signed [CNT_W-1:0]   cnt_q [N_ENTRY];

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_slot
    logic hit_claim, hit_free, hit_upd;
    assign hit_claim = claim_en && (claim_idx == IDX_W'(e));
    assign hit_free  = free_en  && (free_idx  == IDX_W'(e));
    assign hit_upd   = upd_en   && (upd_idx   == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        claimed_q[e] <= 1'b0;
        cnt_q[e]     <= '0;
      end else if (hit_claim) begin
        claimed_q[e] <= 1'b1;
        cnt_q[e]     <= '0;
      end else if (hit_free) begin
        claimed_q[e] <= 1'b0;
        cnt_q[e]     <= '0;
      end else if (hit_upd) begin
        cnt_q[e]     <= upd_val;
      end
    end
  end

  assign rd_claimed = claimed_q[rd_idx];
  assign rd_cnt     = cnt_q[rd_idx];

endmodule

// File: rtl/rsp_classify.sv
module rsp_classify
  import coh_rsp_pkg::*;
#(
  parameter int ACK_W   = 4,
  parameter int CNT_W   = 6,
  parameter int STATE_W = 3
) (
  input  logic [2:0]              kind,
  input  logic                    from_l1,
  input  logic [STATE_W-1:0]      line_state,
  input  logic signed [ACK_W-1:0] carried,
  input  logic signed [CNT_W-1:0] pending,
  input  logic                    claimed,
  output evt_code_e               code,
  output logic signed [CNT_W-1:0] remain,
  output logic                    store
);

  function automatic logic signed [CNT_W-1:0] acks_left(
    input logic signed [CNT_W-1:0] have,
    input logic signed [ACK_W-1:0] got
  );
    logic signed [CNT_W-1:0] got_ext;
    got_ext   = CNT_W'(got);
    acks_left = have - got_ext;
  endfunction

  logic signed [CNT_W-1:0] left;
  logic                    load_pending;

  assign left         = acks_left(pending, carried);
  assign load_pending = (line_state == STATE_W'(LS_LOAD_WAIT)) ||
                        (line_state == STATE_W'(LS_LOAD_WAIT_INV));

  always_comb begin
    code   = EV_FAULT;
    remain = '0;
    store  = 1'b0;
    if (claimed) begin
      case (kind)
        MSG_DATA_EXCL: begin
          code   = EV_DATA_EXCL;
          remain = pending;
        end
        MSG_DATA: begin
          if (from_l1 && load_pending) begin
            code   = EV_DATA_PEER;
            remain = pending;
          end else begin
            code   = (left == '0) ? EV_DATA_DONE : EV_DATA_PART;
            remain = left;
            store  = 1'b1;
          end
        end
        MSG_ACK: begin
          code   = (left == '0) ? EV_ACK_DONE : EV_ACK_PART;
          remain = left;
          store  = 1'b1;
        end
        MSG_WB_ACK: begin
          code   = EV_WB_DONE;
          remain = pending;
        end
        default: begin
          code   = EV_FAULT;
          remain = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/rsp_event_stage.sv
module rsp_event_stage
  import coh_rsp_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int CNT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_fire,
  input  evt_code_e               in_code,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic signed [CNT_W-1:0] in_remain,
  output logic                    can_take,
  output logic                    out_valid,
  input  logic                    out_ready,
  output evt_code_e               out_code,
  output logic [IDX_W-1:0]        out_idx,
  output logic signed [CNT_W-1:0] out_remain
);

  logic valid_q;

  assign can_take  = !valid_q || out_ready;
  assign out_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      out_code   <= EV_FAULT;
      out_idx    <= '0;
      out_remain <= '0;
    end else if (in_fire) begin
      valid_q    <= 1'b1;
      out_code   <= in_code;
      out_idx    <= in_idx;
      out_remain <= in_remain;
    end else if (out_ready) begin
      valid_q    <= 1'b0;
    end
  end

endmodule

// File: rtl/coh_rsp_classifier.sv
module coh_rsp_classifier
  import coh_rsp_pkg::*;
#(
  parameter int N_ENTRY = 4,
  parameter int ACK_W   = 4,
  parameter int CNT_W   = 6,
  parameter int STATE_W = 3,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic               release_valid,
  input  logic [IDX_W-1:0]   release_idx,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [2:0]         rsp_kind,
  input  logic               rsp_from_l1,
  input  logic [ACK_W-1:0]   rsp_acks,
  input  logic [IDX_W-1:0]   rsp_idx,
  input  logic [STATE_W-1:0] line_state,
  output logic               ev_valid,
  input  logic               ev_ready,
  output logic [2:0]         ev_code,
  output logic [IDX_W-1:0]   ev_idx,
  output logic [CNT_W-1:0]   ev_remain
);

  // Named internal events, visible to the bound checker
  logic                    acc_fire;
  logic                    acc_alloc;
  logic                    acc_store;
  evt_code_e               acc_code;
  logic signed [CNT_W-1:0] acc_remain;
  logic signed [CNT_W-1:0] acc_pending;

  evt_code_e               stage_code;
  logic signed [CNT_W-1:0] stage_remain;

  assign acc_fire = rsp_valid && rsp_ready;

  rsp_ack_ledger #(.N_ENTRY(N_ENTRY), .CNT_W(CNT_W)) u_ledger (
    .clk        (clk),
    .rst_n      (rst_n),
    .claim_en   (alloc_valid),
    .claim_idx  (alloc_idx),
    .free_en    (release_valid),
    .free_idx   (release_idx),
    .upd_en     (acc_fire && acc_store),
    .upd_idx    (rsp_idx),
    .upd_val    (acc_remain),
    .rd_idx     (rsp_idx),
    .rd_claimed (acc_alloc),
    .rd_cnt     (acc_pending)
  );

  rsp_classify #(.ACK_W(ACK_W), .CNT_W(CNT_W), .STATE_W(STATE_W)) u_class (
    .kind       (rsp_kind),
    .from_l1    (rsp_from_l1),
    .line_state (line_state),
    .carried    (rsp_acks),
    .pending    (acc_pending),
    .claimed    (acc_alloc),
    .code       (acc_code),
    .remain     (acc_remain),
    .store      (acc_store)
  );

  rsp_event_stage #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_fire    (acc_fire),
    .in_code    (acc_code),
    .in_idx     (rsp_idx),
    .in_remain  (acc_remain),
    .can_take   (rsp_ready),
    .out_valid  (ev_valid),
    .out_ready  (ev_ready),
    .out_code   (stage_code),
    .out_idx    (ev_idx),
    .out_remain (stage_remain)
  );

  assign ev_code   = stage_code;
  assign ev_remain = stage_remain;

endmodule

// File: rtl/coh_rsp_classifier_chk.sv
module coh_rsp_classifier_chk #(
  parameter int IDX_W = 2,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_fire,
  input logic             acc_alloc,
  input logic [2:0]       rsp_kind,
  input logic [IDX_W-1:0] rsp_idx,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [2:0]       ev_code,
  input logic [IDX_W-1:0] ev_idx,
  input logic [CNT_W-1:0] ev_remain
);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_idx) && $stable(ev_remain));

  // R10
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> ev_valid && (ev_idx == $past(rsp_idx)));

  // R9
  free_slot_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_alloc |=> ev_code == 3'd7 && ev_remain == '0);

  // R2
  excl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_alloc && rsp_kind == 3'd1 |=> ev_code == 3'd0);

  // R8
  wb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_alloc && rsp_kind == 3'd3 |=> ev_code == 3'd6);

  // R4
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && (ev_code == 3'd2 || ev_code == 3'd4) |-> ev_remain == '0);

  // R6
  part_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && (ev_code == 3'd3 || ev_code == 3'd5) |-> ev_remain != '0);

endmodule

bind coh_rsp_classifier coh_rsp_classifier_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_fire  (acc_fire),
  .acc_alloc (acc_alloc),
  .rsp_kind  (rsp_kind),
  .rsp_idx   (rsp_idx),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .ev_code   (ev_code),
  .ev_idx    (ev_idx),
  .ev_remain (ev_remain)
);

// File: tb/tb_coh_rsp_classifier.sv
`timescale 1ns/1ps
module tb_coh_rsp_classifier;

  localparam int N  = 4;
  localparam int AW = 4;
  localparam int CW = 6;
  localparam int SW = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0, release_valid = 1'b0;
  logic [IW-1:0] alloc_idx = '0, release_idx = '0, rsp_idx = '0;
  logic          rsp_valid = 1'b0, rsp_from_l1 = 1'b0, ev_ready = 1'b1;
  logic [2:0]    rsp_kind = '0;
  logic [AW-1:0] rsp_acks = '0;
  logic [SW-1:0] line_state = '0;
  logic          rsp_ready, ev_valid;
  logic [2:0]    ev_code;
  logic [IW-1:0] ev_idx;
  logic [CW-1:0] ev_remain;

  coh_rsp_classifier #(.N_ENTRY(N), .ACK_W(AW), .CNT_W(CW), .STATE_W(SW)) dut (.*);

  always #10 clk = ~clk;   // 50 MHz

  int    checks = 0, fails = 0;
  bit    done = 1'b0;
  string phase = "R1 reset";

  // ---------------- behavioural reference model ----------------
  bit m_alloc [N];
  int m_pend  [N];
  bit m_v;
  int m_code, m_idx, m_rem;

  function automatic int wrapc(int v);
    int m;
    m = v & ((1 << CW) - 1);
    if (m >= (1 << (CW - 1))) m = m - (1 << CW);
    return m;
  endfunction

  function automatic int acks_int(logic [AW-1:0] a);
    return (a >= (1 << (AW - 1))) ? int'(a) - (1 << AW) : int'(a);
  endfunction

  function automatic string req_of(int c);
    case (c)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_v = 0; m_code = 7; m_idx = 0; m_rem = 0;
      for (int i = 0; i < N; i++) begin m_alloc[i] = 0; m_pend[i] = 0; end
    end else begin
      bit rdy;
      rdy = !m_v || ev_ready;
      if (m_v && ev_ready) m_v = 0;
      if (rsp_valid && rdy) begin
        int p, d;
        p = m_pend[rsp_idx];
        d = wrapc(p - acks_int(rsp_acks));
        m_v = 1; m_idx = rsp_idx;
        if (!m_alloc[rsp_idx] || rsp_kind > 3) begin
          m_code = 7; m_rem = 0;
        end else if (rsp_kind == 1) begin
          m_code = 0; m_rem = p;
        end else if (rsp_kind == 3) begin
          m_code = 6; m_rem = p;
        end else if (rsp_kind == 0 && rsp_from_l1 && (line_state == 1 || line_state == 2)) begin
          m_code = 1; m_rem = p;
        end else begin
          if (rsp_kind == 0) m_code = (d == 0) ? 2 : 3;
          else               m_code = (d == 0) ? 4 : 5;
          m_rem = d;
          m_pend[rsp_idx] = d;
        end
      end
      if (release_valid) begin m_alloc[release_idx] = 0; m_pend[release_idx] = 0; end
      if (alloc_valid)   begin m_alloc[alloc_idx]   = 1; m_pend[alloc_idx]   = 0; end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, phase, what, act, exp);
    end
  endtask

  // compare every cycle, 5 ns after the active edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check(rsp_ready == (!m_v || ev_ready), "R10", "rsp_ready", rsp_ready, !m_v || ev_ready);
      check(ev_valid == m_v, "R10", "ev_valid", ev_valid, m_v);
      if (m_v && ev_valid) begin
        check(ev_code == 3'(m_code), req_of(m_code), "ev_code", ev_code, m_code);
        check(ev_idx == IW'(m_idx), "R10", "ev_idx", ev_idx, m_idx);
        check(int'($signed(ev_remain)) == m_rem, "R6", "ev_remain", int'($signed(ev_remain)), m_rem);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic claim(int idx);
    @(negedge clk); alloc_valid = 1; alloc_idx = IW'(idx);
    @(negedge clk); alloc_valid = 0;
  endtask

  task automatic free_slot(int idx);
    @(negedge clk); release_valid = 1; release_idx = IW'(idx);
    @(negedge clk); release_valid = 0;
  endtask

  task automatic send(int idx, int kind, bit l1, int acks, int st);
    @(negedge clk);
    rsp_valid = 1; rsp_idx = IW'(idx); rsp_kind = 3'(kind);
    rsp_from_l1 = l1; rsp_acks = AW'(acks); line_state = SW'(st);
    #1;
    while (!rsp_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); rsp_valid = 0;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(ev_valid == 0, "R1", "ev_valid after reset", ev_valid, 0);
    check(rsp_ready == 1, "R1", "rsp_ready after reset", rsp_ready, 1);

    phase = "R1 free slot after reset";
    send(2, 2, 0, 1, 0);                  // expects fault

    for (int i = 0; i < N; i++) claim(i);

    phase = "R5 R6 acks before data";
    send(0, 2, 0, 1, 3);                  // -1 partial ack
    send(0, 2, 0, 1, 3);                  // -2
    send(0, 0, 0, -3, 3);                 // 1 partial data
    send(0, 2, 0, 1, 3);                  // 0 ack done

    phase = "R4 data before acks";
    send(1, 0, 0, -2, 4);                 // 2 partial data
    send(1, 2, 0, 1, 4);
    send(1, 2, 0, 1, 4);                  // ack done
    send(1, 0, 0, 0, 4);                  // data done

    phase = "R3 peer data";
    send(2, 0, 1, 0, 1);                  // peer data, IS
    send(2, 0, 1, 2, 2);                  // peer data, IS_I, no count change
    send(2, 0, 1, 0, 3);                  // from L1 but not load pending
    send(2, 0, 0, 0, 1);                  // load pending but not from L1

    phase = "R2 R8 R9 kinds";
    send(3, 2, 0, 2, 0);                  // pending -2
    send(3, 1, 0, 5, 0);                  // exclusive ignores counts
    send(3, 3, 0, 0, 0);                  // writeback ack
    send(3, 5, 0, 1, 0);                  // unknown kind
    send(3, 2, 0, -2, 0);                 // count unchanged by the above: done

    phase = "R7 release over update";
    claim(3);
    send(3, 2, 0, 1, 0);                  // -1
    @(negedge clk);
    release_valid = 1; release_idx = 3;
    rsp_valid = 1; rsp_idx = 3; rsp_kind = 2; rsp_acks = 1; line_state = 0;
    #1; while (!rsp_ready) begin @(negedge clk); #1; end
    @(negedge clk); release_valid = 0; rsp_valid = 0;
    send(3, 2, 0, 1, 0);                  // freed -> fault
    claim(3);
    send(3, 2, 0, 1, 0);                  // restarts at 0 -> -1

    phase = "R10 backpressure";
    @(negedge clk); ev_ready = 0;
    fork
      begin send(0, 2, 0, 1, 0); send(1, 2, 0, -1, 0); end
      begin repeat (6) @(negedge clk); ev_ready = 1; end
    join

    phase = "random mix";
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      rsp_valid   = ($urandom % 3) != 0;
      rsp_idx     = IW'($urandom);
      rsp_kind    = (($urandom % 8) == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
      rsp_from_l1 = 1'($urandom);
      rsp_acks    = AW'(int'($urandom % 7) - 3);
      line_state  = SW'($urandom % 5);
      ev_ready    = ($urandom % 4) != 0;
      alloc_valid   = ($urandom % 8) == 0;
      alloc_idx     = IW'($urandom);
      release_valid = ($urandom % 10) == 0;
      release_idx   = IW'($urandom);
    end
    @(negedge clk);
    rsp_valid = 0; alloc_valid = 0; release_valid = 0; ev_ready = 1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog [%s]: actual timeout expected completion", phase);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule